// File: doc/BRIEF.md
# Self-Modifying Code Store Detector

This block sits between a split instruction cache and data cache. It watches for stores that land on lines which may hold instructions the front end has already fetched. Each fetch in flight gets a fetch ID from a small table. The table records only where that fetch's line sits in the I-cache, as a set index and a way. It does not keep the line address.

Because an entry names a cache slot and not an address, any event that empties or reuses that slot must drop the fetch IDs that point at it. The slot can be lost in four ways: a replacement, an external cross-invalidate, an internal cross-invalidate raised by a store, or a purge of the whole cache. For each loss the block reports the affected IDs to the execution side as a bit mask.

For stores, the block asks the I-cache to drop the target line when either of two things is true: the data cache does not hold the line exclusively, or the store lands on a slot with a live fetch ID. In the second case it also reports a store hit, so the execution side can discard instructions that the store has made stale.

Top module: `smc_detect`

## Requirements
- R1: After reset, every fetch ID is free, `alloc_avail_o` is 1, `alloc_id_o` is 0, and `inv_mask_o`, `ixi_valid_o` and `store_hit_o` are 0.
- R2: `alloc_id_o` always shows the lowest free entry. `alloc_avail_o` is 0 only when all entries are valid. An allocate request taken while `alloc_avail_o` is 1 makes that entry valid, holding the given set and way. An allocate request taken while the table is full has no effect.
- R3: A replacement at a set/way makes every valid entry with that set/way invalid. Those entries appear as 1 bits (bit i = entry i) in `inv_mask_o` on the cycle after the event.
- R4: An external cross-invalidate at a set/way behaves as in R3 for the entries with that set/way.
- R5: A purge makes all valid entries invalid in one cycle, and `inv_mask_o` on the next cycle equals the set of entries that were valid.
- R6: A store with `store_excl_i` = 0 raises `ixi_valid_o` on the next cycle, with `ixi_set_o`/`ixi_way_o` equal to the store's set/way.
- R7: A store whose set/way matches a valid entry raises both `store_hit_o` and `ixi_valid_o` on the next cycle, whatever its exclusivity. The matching entries are made invalid and reported in `inv_mask_o`.
- R8: A store with `store_excl_i` = 1 that matches no valid entry raises neither `ixi_valid_o` nor `store_hit_o`.
- R9: When several loss events occur in the same cycle, `inv_mask_o` is the OR of the entries each event matches.
- R10: A retire frees its entry without setting any `inv_mask_o` bit. An entry retired in the same cycle as a loss event that matches it is still reported in `inv_mask_o`.
- R11: `inv_mask_o` never has a bit set for an entry that was not valid in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocate a fetch ID |
| alloc_set_i | input | SET_W | I-cache set of the fetched line |
| alloc_way_i | input | WAY_W | I-cache way of the fetched line |
| alloc_avail_o | output | 1 | A free entry exists |
| alloc_id_o | output | ID_W | Lowest free entry index |
| retire_i | input | 1 | Retire a fetch ID |
| retire_id_i | input | ID_W | Fetch ID being retired |
| repl_i | input | 1 | Line replacement event |
| repl_set_i | input | SET_W | Replaced set |
| repl_way_i | input | WAY_W | Replaced way |
| xi_i | input | 1 | External cross-invalidate event |
| xi_set_i | input | SET_W | Cross-invalidated set |
| xi_way_i | input | WAY_W | Cross-invalidated way |
| purge_i | input | 1 | Purge of the whole I-cache |
| store_i | input | 1 | Store request |
| store_set_i | input | SET_W | I-cache set the store maps to |
| store_way_i | input | WAY_W | I-cache way the store maps to |
| store_excl_i | input | 1 | Line is held exclusively in the D-cache |
| inv_mask_o | output | N_IDS | Fetch IDs to invalidate, one bit per entry |
| ixi_valid_o | output | 1 | Internal cross-invalidate request to the I-cache |
| ixi_set_o | output | SET_W | Set of the internal cross-invalidate |
| ixi_way_o | output | WAY_W | Way of the internal cross-invalidate |
| store_hit_o | output | 1 | Store hit a valid fetch ID |

## Verification
`alloc_avail_o` and `alloc_id_o` are combinational views of the table. They are compared while the inputs for a cycle are held, before the clock edge. `inv_mask_o`, `ixi_*` and `store_hit_o` come out of registers, so each one is due exactly one edge after the stimulus that caused it. The bench drives on the falling edge, moves its reference model forward one step, and compares all registered outputs on the next falling edge. Corner cases that share a cycle are placed deliberately: retire together with a matching loss, three loss sources at once, and an allocate request while the table is full. A random phase follows, using a small set/way range so that events often collide.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
  localparam int unsigned SMC_IDS   = 8;
  localparam int unsigned SMC_SET_W = 6;
  localparam int unsigned SMC_WAY_W = 2;

  // per-location loss sources, each with its own matcher
  typedef enum int unsigned {
    LS_REPL  = 0,
    LS_XI    = 1,
    LS_STORE = 2
  } loss_src_e;
  localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/smc_alloc.sv
`timescale 1ns/1ps
module smc_alloc #(
  parameter int unsigned N_IDS = 8,
  localparam int unsigned ID_W = $clog2(N_IDS)
) (
  input  logic [N_IDS-1:0] busy_i,
  output logic             avail_o,
  output logic [ID_W-1:0]  id_o,
  output logic [N_IDS-1:0] grant_o
);
  // lowest free index wins
  always_comb begin
    avail_o = 1'b0;
    id_o    = '0;
    grant_o = '0;
    for (int i = N_IDS - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        avail_o    = 1'b1;
        id_o       = ID_W'(i);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/smc_match.sv
`timescale 1ns/1ps
module smc_match #(
  parameter int unsigned N_IDS = 8,
  parameter int unsigned SET_W = 6,
  parameter int unsigned WAY_W = 2
) (
  input  logic [N_IDS-1:0]            valid_i,
  input  logic [N_IDS-1:0][SET_W-1:0] set_tab_i,
  input  logic [N_IDS-1:0][WAY_W-1:0] way_tab_i,
  input  logic                        ev_i,
  input  logic [SET_W-1:0]            ev_set_i,
  input  logic [WAY_W-1:0]            ev_way_i,
  output logic [N_IDS-1:0]            hit_o
);
  for (genvar e = 0; e < N_IDS; e++) begin : g_cmp
    assign hit_o[e] = ev_i && valid_i[e] &&
                      (set_tab_i[e] == ev_set_i) && (way_tab_i[e] == ev_way_i);
  end
endmodule

// File: rtl/smc_detect.sv
`timescale 1ns/1ps
module smc_detect
  import smc_pkg::*;
#(
  parameter int unsigned N_IDS = SMC_IDS,
  parameter int unsigned SET_W = SMC_SET_W,
  parameter int unsigned WAY_W = SMC_WAY_W,
  localparam int unsigned ID_W = $clog2(N_IDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  input  logic [SET_W-1:0] alloc_set_i,
  input  logic [WAY_W-1:0] alloc_way_i,
  output logic             alloc_avail_o,
  output logic [ID_W-1:0]  alloc_id_o,
  input  logic             retire_i,
  input  logic [ID_W-1:0]  retire_id_i,
  input  logic             repl_i,
  input  logic [SET_W-1:0] repl_set_i,
  input  logic [WAY_W-1:0] repl_way_i,
  input  logic             xi_i,
  input  logic [SET_W-1:0] xi_set_i,
  input  logic [WAY_W-1:0] xi_way_i,
  input  logic             purge_i,
  input  logic             store_i,
  input  logic [SET_W-1:0] store_set_i,
  input  logic [WAY_W-1:0] store_way_i,
  input  logic             store_excl_i,
  output logic [N_IDS-1:0] inv_mask_o,
  output logic             ixi_valid_o,
  output logic [SET_W-1:0] ixi_set_o,
  output logic [WAY_W-1:0] ixi_way_o,
  output logic             store_hit_o
);
  logic [N_IDS-1:0]            valid_q;
  logic [N_IDS-1:0][SET_W-1:0] set_q;
  logic [N_IDS-1:0][WAY_W-1:0] way_q;

  logic [NUM_SRC-1:0]              src_v;
  logic [NUM_SRC-1:0][SET_W-1:0]   src_set;
  logic [NUM_SRC-1:0][WAY_W-1:0]   src_way;
  logic [NUM_SRC-1:0][N_IDS-1:0]   src_hit;

  logic [N_IDS-1:0] grant;
  logic [N_IDS-1:0] loss;
  logic [N_IDS-1:0] retire_mask;
  logic [N_IDS-1:0] valid_d;
  logic             st_hit;
  logic             ixi_req;

  assign src_v[LS_REPL]    = repl_i;
  assign src_set[LS_REPL]  = repl_set_i;
  assign src_way[LS_REPL]  = repl_way_i;
  assign src_v[LS_XI]      = xi_i;
  assign src_set[LS_XI]    = xi_set_i;
  assign src_way[LS_XI]    = xi_way_i;
  // the store's own internal XI drops any fetch ID at its slot
  assign src_v[LS_STORE]   = store_i;
  assign src_set[LS_STORE] = store_set_i;
  assign src_way[LS_STORE] = store_way_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    smc_match #(
      .N_IDS(N_IDS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_match (
      .valid_i  (valid_q),
      .set_tab_i(set_q),
      .way_tab_i(way_q),
      .ev_i     (src_v[s]),
      .ev_set_i (src_set[s]),
      .ev_way_i (src_way[s]),
      .hit_o    (src_hit[s])
    );
  end

  smc_alloc #(.N_IDS(N_IDS)) u_alloc (
    .busy_i (valid_q),
    .avail_o(alloc_avail_o),
    .id_o   (alloc_id_o),
    .grant_o(grant)
  );

  always_comb begin
    loss = purge_i ? valid_q : '0;
    for (int s = 0; s < NUM_SRC; s++) loss |= src_hit[s];
  end

  assign st_hit      = |src_hit[LS_STORE];
  assign ixi_req     = store_i && (!store_excl_i || st_hit);
  assign retire_mask = retire_i ? (N_IDS'(1) << retire_id_i) : '0;
  assign valid_d     = (valid_q & ~loss & ~retire_mask) | (alloc_req_i ? grant : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      set_q   <= '0;
      way_q   <= '0;
    end else begin
      valid_q <= valid_d;
      for (int i = 0; i < N_IDS; i++) begin
        if (alloc_req_i && grant[i]) begin
          set_q[i] <= alloc_set_i;
          way_q[i] <= alloc_way_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_mask_o  <= '0;
      ixi_valid_o <= 1'b0;
      ixi_set_o   <= '0;
      ixi_way_o   <= '0;
      store_hit_o <= 1'b0;
    end else begin
      inv_mask_o  <= loss;
      ixi_valid_o <= ixi_req;
      ixi_set_o   <= store_set_i;
      ixi_way_o   <= store_way_i;
      store_hit_o <= store_i && st_hit;
    end
  end
endmodule

// File: rtl/smc_detect_chk.sv
`timescale 1ns/1ps
module smc_detect_chk #(
  parameter int unsigned N_IDS = 8,
  parameter int unsigned SET_W = 6,
  parameter int unsigned WAY_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IDS-1:0] valid_q,
  input logic             alloc_avail_o,
  input logic             purge_i,
  input logic             store_i,
  input logic [SET_W-1:0] store_set_i,
  input logic [WAY_W-1:0] store_way_i,
  input logic             store_excl_i,
  input logic [N_IDS-1:0] inv_mask_o,
  input logic             ixi_valid_o,
  input logic [SET_W-1:0] ixi_set_o,
  input logic [WAY_W-1:0] ixi_way_o,
  input logic             store_hit_o
);
  a_r2_full_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_avail_o |-> (&valid_q));

  a_r5_purge_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_i |=> (inv_mask_o == $past(valid_q)));

  a_r6_nonexcl_ixi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !store_excl_i) |=>
      (ixi_valid_o && ixi_set_o == $past(store_set_i) && ixi_way_o == $past(store_way_i)));

  a_r7_hit_has_ixi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_hit_o |-> ixi_valid_o);

  a_r8_excl_ixi_iff_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && store_excl_i) |=> (ixi_valid_o == store_hit_o));

  a_r8_no_store_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> (!ixi_valid_o && !store_hit_o));

  a_r11_mask_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((inv_mask_o & ~$past(valid_q)) == '0));
endmodule

bind smc_detect smc_detect_chk #(
  .N_IDS(N_IDS), .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_q      (valid_q),
  .alloc_avail_o(alloc_avail_o),
  .purge_i      (purge_i),
  .store_i      (store_i),
  .store_set_i  (store_set_i),
  .store_way_i  (store_way_i),
  .store_excl_i (store_excl_i),
  .inv_mask_o   (inv_mask_o),
  .ixi_valid_o  (ixi_valid_o),
  .ixi_set_o    (ixi_set_o),
  .ixi_way_o    (ixi_way_o),
  .store_hit_o  (store_hit_o)
);

// File: tb/smc_detect_test.sv
`timescale 1ns/1ps
module smc_detect_test;
  localparam int N = 8;
  localparam int SW = 6;
  localparam int WW = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 0, retire = 0, repl = 0, xi = 0, purge = 0, store = 0, excl = 0;
  logic [SW-1:0] alloc_set = 0, repl_set = 0, xi_set = 0, store_set = 0;
  logic [WW-1:0] alloc_way = 0, repl_way = 0, xi_way = 0, store_way = 0;
  logic [IW-1:0] retire_id = 0;
  logic          avail;
  logic [IW-1:0] aid;
  logic [N-1:0]  inv_mask;
  logic          ixi_v, hit;
  logic [SW-1:0] ixi_set;
  logic [WW-1:0] ixi_way;

  int checks = 0, errors = 0;
  bit mv[N];
  int ms[N], mw[N];

  always #2.5 clk = ~clk;

  smc_detect uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_req_i(alloc_req), .alloc_set_i(alloc_set), .alloc_way_i(alloc_way),
    .alloc_avail_o(avail), .alloc_id_o(aid),
    .retire_i(retire), .retire_id_i(retire_id),
    .repl_i(repl), .repl_set_i(repl_set), .repl_way_i(repl_way),
    .xi_i(xi), .xi_set_i(xi_set), .xi_way_i(xi_way),
    .purge_i(purge),
    .store_i(store), .store_set_i(store_set), .store_way_i(store_way), .store_excl_i(excl),
    .inv_mask_o(inv_mask), .ixi_valid_o(ixi_v), .ixi_set_o(ixi_set), .ixi_way_o(ixi_way),
    .store_hit_o(hit)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    alloc_req = 0; retire = 0; repl = 0; xi = 0; purge = 0; store = 0; excl = 0;
  endtask

  // one cycle: inputs already driven at the falling edge
  task automatic step(input string tag);
    int lo;
    logic [N-1:0] loss;
    logic [N-1:0] st_m;
    bit e_hit, e_ixi;
    int s_set, s_way;
    lo = -1;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) lo = i;
    chk(tag, "alloc_avail", avail, lo >= 0);
    if (lo >= 0) chk(tag, "alloc_id", aid, lo);
    loss = '0; st_m = '0;
    for (int i = 0; i < N; i++) begin
      if (mv[i]) begin
        if (purge) loss[i] = 1;
        if (repl && ms[i] == repl_set && mw[i] == repl_way) loss[i] = 1;
        if (xi && ms[i] == xi_set && mw[i] == xi_way) loss[i] = 1;
        if (store && ms[i] == store_set && mw[i] == store_way) begin loss[i] = 1; st_m[i] = 1; end
      end
    end
    e_hit = store && (st_m != 0);
    e_ixi = store && (!excl || e_hit);
    s_set = store_set; s_way = store_way;
    for (int i = 0; i < N; i++) begin
      if (loss[i]) mv[i] = 0;
      if (retire && retire_id == i) mv[i] = 0;
    end
    if (alloc_req && lo >= 0) begin mv[lo] = 1; ms[lo] = alloc_set; mw[lo] = alloc_way; end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "inv_mask", inv_mask, loss);
    chk(tag, "ixi_valid", ixi_v, e_ixi);
    chk(tag, "store_hit", hit, e_hit);
    if (e_ixi) begin
      chk(tag, "ixi_set", ixi_set, s_set);
      chk(tag, "ixi_way", ixi_way, s_way);
    end
    clr();
  endtask

  task automatic do_alloc(input int s, input int w, input string tag);
    alloc_req = 1; alloc_set = SW'(s); alloc_way = WW'(w); step(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; ms[i] = 0; mw[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "alloc_avail", avail, 1);
    chk("R1", "alloc_id", aid, 0);
    chk("R1", "inv_mask", inv_mask, 0);
    chk("R1", "ixi_valid", ixi_v, 0);
    chk("R1", "store_hit", hit, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 fill table; entries 2 and 6 share a slot
    for (int i = 0; i < N; i++)
      if (i == 6) do_alloc(10, 1, "R2");
      else if (i == 2) do_alloc(10, 1, "R2");
      else do_alloc(i * 3 + 20, i % 4, "R2");
    chk("R2", "full_avail", avail, 0);
    do_alloc(5, 0, "R2");                 // ignored while full
    // R3 replacement of entry 0's slot
    repl = 1; repl_set = 20; repl_way = 0; step("R3");
    // R4 external XI of the shared slot -> entries 2 and 6
    xi = 1; xi_set = 10; xi_way = 1; step("R4");
    // R10 plain retire: no report
    retire = 1; retire_id = 1; step("R10");
    do_alloc(40, 3, "R2");                // lowest free is 0
    // R8 exclusive store, no match
    store = 1; excl = 1; store_set = 63; store_way = 3; step("R8");
    // R6 non-exclusive store, no match
    store = 1; excl = 0; store_set = 62; store_way = 2; step("R6");
    // R7 exclusive store onto entry 3 (set 29 way 3)
    store = 1; excl = 1; store_set = 29; store_way = 3; step("R7");
    // R9 three sources at once: entries 4, 5, 7
    repl = 1; repl_set = 32; repl_way = 0;
    xi = 1; xi_set = 35; xi_way = 1;
    store = 1; excl = 0; store_set = 41; store_way = 3; step("R9");
    // R10 retire entry 0 while replaced
    retire = 1; retire_id = 0; repl = 1; repl_set = 40; repl_way = 3; step("R10");
    // R5 purge
    do_alloc(1, 1, "R2"); do_alloc(2, 2, "R2"); do_alloc(3, 0, "R2");
    purge = 1; step("R5");
    // R11 random mix on a small slot range
    for (int c = 0; c < 400; c++) begin
      alloc_req = ($urandom % 2) == 0; alloc_set = SW'($urandom % 4); alloc_way = WW'($urandom % 2);
      retire = ($urandom % 4) == 0; retire_id = IW'($urandom % N);
      repl = ($urandom % 5) == 0; repl_set = SW'($urandom % 4); repl_way = WW'($urandom % 2);
      xi = ($urandom % 6) == 0; xi_set = SW'($urandom % 4); xi_way = WW'($urandom % 2);
      store = ($urandom % 3) == 0; excl = ($urandom % 2) == 0;
      store_set = SW'($urandom % 4); store_way = WW'($urandom % 2);
      purge = ($urandom % 60) == 0;
      step("R11");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule